// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block computes two memory addresses in every clock cycle, one for each of two independent address ports, so that two data fetches can be issued together. It holds four circular register sets. Each set has a 32-bit index, a signed 32-bit step, a 32-bit span and a 32-bit origin. It also holds eight 32-bit pointer registers. The pointer registers give stack-style indexed access and never wrap.

On each request a port names a register. It receives either the current value of that register (post-modify) or the stepped value (pre-modify). It may also write the stepped value back. For a circular set, the stepped value is folded into the window that starts at origin and spans span bytes. A span of zero means plain linear stepping.

Registers are loaded through a write port and read through a combinational read port. The address outputs and the collision flag are combinational from the current register state. Every register update takes effect at the next rising clock edge.

Top module: `circ_addr_unit`

## Requirements
- R1: An active-low reset clears every register to zero. A read through `cfg_rdata` then returns 0 for every register address.
- R2: Register address encoding on `cfg_waddr` and `cfg_raddr`:
  - Bit 4 = 1 selects pointer register `addr[2:0]`.
  - Bit 4 = 0 selects the circular set `addr[1:0]`, and bits [3:2] pick the field: 0 index, 1 step, 2 span, 3 origin.
  - A write with `cfg_we` high is visible on the read port and on the address outputs after the next rising edge.
- R3: An address produced in the same cycle as a register write uses the value from before the write.
- R4: Both ports operate in parallel.
  - With `agu_pre` low, `agu_addr` equals the current register value.
  - With `agu_pre` high, `agu_addr` equals the stepped and wrapped value.
- R5: A port with `agu_req` and `agu_upd` high writes the stepped and wrapped value into its register at the next rising edge. With `agu_upd` low the register keeps its value.
- R6: For a circular set with nonzero span, a stepped value at or above origin+span is reduced by span.
- R7: For a circular set with nonzero span, a stepped value below origin is increased by span.
- R8: A span of zero disables wrapping, so the stepped value is index+step.
- R9: The step register is signed two's complement, so a negative step moves the index downward.
- R10: With `agu_is_ptr` high, a port uses pointer register `agu_sel[2:0]` stepped by its own `agu_step` input (signed), with no wrapping.
- R11: When both ports update the same register in one cycle:
  - Port 0's value is stored.
  - `coll_err` is high in that cycle.
  - `coll_err` is low in every other case.
- R12: A register write has priority over a port writeback to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| cfg_we | input | 1 | Register write enable |
| cfg_waddr | input | 5 | Register write address (R2 encoding) |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 5 | Register read address (R2 encoding) |
| cfg_rdata | output | 32 | Register read data, combinational |
| agu_req | input | 2 | Per-port request |
| agu_is_ptr | input | 2 | Per-port: 1 uses a pointer register, 0 a circular set |
| agu_sel | input | 2x3 | Per-port register select |
| agu_pre | input | 2 | Per-port: 1 pre-modify, 0 post-modify |
| agu_upd | input | 2 | Per-port: write the stepped value back |
| agu_step | input | 2x32 | Per-port signed step for pointer mode |
| agu_addr | output | 2x32 | Per-port generated address |
| coll_err | output | 1 | Both ports updated the same register this cycle |

## Verification
Results arrive at two latencies:
- `agu_addr` and `coll_err` respond in the same cycle as the request, because they are pure logic on the register state.
- Register updates, whether from a write or a port writeback, appear only after the following rising edge.

The bench changes inputs on the falling edge and samples combinational results one time unit later, well before the next rising edge. For register effects it waits one rising edge and then one falling edge, and reads the register back through `cfg_rdata`. The same-cycle old-value case and the write-versus-writeback priority case each depend on this one-edge split, and are checked on each side of it.

// File: rtl/cag_pkg.sv
package cag_pkg;
    localparam int unsigned CAG_AW    = 32;
    localparam int unsigned CAG_NSETS = 4;
    localparam int unsigned CAG_NPTR  = 8;
    localparam int unsigned CAG_SETW  = $clog2(CAG_NSETS);
    localparam int unsigned CAG_PTRW  = $clog2(CAG_NPTR);
    localparam int unsigned CAG_SELW  = (CAG_PTRW > CAG_SETW) ? CAG_PTRW : CAG_SETW;
    localparam int unsigned CAG_CAW   = 1 + (((2 + CAG_SETW) > CAG_PTRW) ? (2 + CAG_SETW) : CAG_PTRW);

    typedef enum logic [1:0] {
        FLD_INDEX  = 2'd0,
        FLD_STEP   = 2'd1,
        FLD_SPAN   = 2'd2,
        FLD_ORIGIN = 2'd3
    } cag_field_e;

    typedef struct packed {
        logic [CAG_AW-1:0] index;
        logic [CAG_AW-1:0] step;
        logic [CAG_AW-1:0] span;
        logic [CAG_AW-1:0] origin;
    } cag_set_t;

    typedef struct packed {
        logic                valid;
        logic                is_ptr;
        logic [CAG_SELW-1:0] sel;
        logic [CAG_AW-1:0]   value;
    } cag_wb_t;
endpackage

// File: rtl/cag_wrap.sv
module cag_wrap
    import cag_pkg::*;
(
    input  logic [CAG_AW-1:0] cur,
    input  logic [CAG_AW-1:0] step,
    input  logic [CAG_AW-1:0] span,
    input  logic [CAG_AW-1:0] origin,
    input  logic              circ,
    output logic [CAG_AW-1:0] nxt
);
    logic [CAG_AW-1:0] sum;
    logic [CAG_AW:0]   limit;

    always_comb begin
        sum   = cur + step;
        limit = {1'b0, origin} + {1'b0, span};
        nxt   = sum;
        if (circ && (span != '0)) begin
            if ({1'b0, sum} >= limit) begin
                nxt = sum - span;
            end else if (sum < origin) begin
                nxt = sum + span;
            end
        end
    end
endmodule

// File: rtl/cag_port.sv
module cag_port
    import cag_pkg::*;
(
    input  cag_set_t [CAG_NSETS-1:0]             sets,
    input  logic     [CAG_NPTR-1:0][CAG_AW-1:0]  ptrs,
    input  logic                                 is_ptr,
    input  logic     [CAG_SELW-1:0]              sel,
    input  logic                                 pre,
    input  logic     [CAG_AW-1:0]                ext_step,
    output logic     [CAG_AW-1:0]                addr,
    output logic     [CAG_AW-1:0]                nxt
);
    cag_set_t          cs;
    logic [CAG_AW-1:0] cur;
    logic [CAG_AW-1:0] stp;
    logic [CAG_AW-1:0] span;
    logic [CAG_AW-1:0] origin;

    always_comb begin
        cs = sets[sel[CAG_SETW-1:0]];
        if (is_ptr) begin
            cur    = ptrs[sel[CAG_PTRW-1:0]];
            stp    = ext_step;
            span   = '0;
            origin = '0;
        end else begin
            cur    = cs.index;
            stp    = cs.step;
            span   = cs.span;
            origin = cs.origin;
        end
    end

    cag_wrap u_wrap (
        .cur    (cur),
        .step   (stp),
        .span   (span),
        .origin (origin),
        .circ   (~is_ptr),
        .nxt    (nxt)
    );

    assign addr = pre ? nxt : cur;
endmodule

// File: rtl/cag_regfile.sv
module cag_regfile
    import cag_pkg::*;
#(
    parameter int unsigned NPORT = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  cag_wb_t  [NPORT-1:0]                 wb,
    input  logic                                 cfg_we,
    input  logic     [CAG_CAW-1:0]               cfg_waddr,
    input  logic     [CAG_AW-1:0]                cfg_wdata,
    output cag_set_t [CAG_NSETS-1:0]             sets,
    output logic     [CAG_NPTR-1:0][CAG_AW-1:0]  ptrs
);
    typedef struct packed {
        cag_set_t [CAG_NSETS-1:0]            sets;
        logic     [CAG_NPTR-1:0][CAG_AW-1:0] ptrs;
    } state_t;

    state_t     st_d, st_q;
    cag_field_e fld;

    always_comb begin
        st_d = st_q;
        fld  = cag_field_e'(cfg_waddr[CAG_SETW+1:CAG_SETW]);
        // Highest port first so that the lowest-numbered port lands last.
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (wb[p].valid) begin
                if (wb[p].is_ptr) begin
                    st_d.ptrs[wb[p].sel[CAG_PTRW-1:0]] = wb[p].value;
                end else begin
                    st_d.sets[wb[p].sel[CAG_SETW-1:0]].index = wb[p].value;
                end
            end
        end
        // Register writes override port writebacks (R12).
        if (cfg_we) begin
            if (cfg_waddr[CAG_CAW-1]) begin
                st_d.ptrs[cfg_waddr[CAG_PTRW-1:0]] = cfg_wdata;
            end else begin
                case (fld)
                    FLD_INDEX:  st_d.sets[cfg_waddr[CAG_SETW-1:0]].index  = cfg_wdata;
                    FLD_STEP:   st_d.sets[cfg_waddr[CAG_SETW-1:0]].step   = cfg_wdata;
                    FLD_SPAN:   st_d.sets[cfg_waddr[CAG_SETW-1:0]].span   = cfg_wdata;
                    default:    st_d.sets[cfg_waddr[CAG_SETW-1:0]].origin = cfg_wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sets = st_q.sets;
    assign ptrs = st_q.ptrs;
endmodule

// File: rtl/circ_addr_unit.sv
module circ_addr_unit
    import cag_pkg::*;
#(
    parameter int unsigned NPORT = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CAG_CAW-1:0]                cfg_waddr,
    input  logic [CAG_AW-1:0]                 cfg_wdata,
    input  logic [CAG_CAW-1:0]                cfg_raddr,
    output logic [CAG_AW-1:0]                 cfg_rdata,
    input  logic [NPORT-1:0]                  agu_req,
    input  logic [NPORT-1:0]                  agu_is_ptr,
    input  logic [NPORT-1:0][CAG_SELW-1:0]    agu_sel,
    input  logic [NPORT-1:0]                  agu_pre,
    input  logic [NPORT-1:0]                  agu_upd,
    input  logic [NPORT-1:0][CAG_AW-1:0]      agu_step,
    output logic [NPORT-1:0][CAG_AW-1:0]      agu_addr,
    output logic                              coll_err
);
    cag_set_t [CAG_NSETS-1:0]             sets;
    logic     [CAG_NPTR-1:0][CAG_AW-1:0]  ptrs;
    logic     [NPORT-1:0][CAG_AW-1:0]     nxt;
    logic     [NPORT-1:0]                 want;
    cag_wb_t  [NPORT-1:0]                 wb;
    cag_set_t                             rd_set;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            cag_port u_port (
                .sets     (sets),
                .ptrs     (ptrs),
                .is_ptr   (agu_is_ptr[g]),
                .sel      (agu_sel[g]),
                .pre      (agu_pre[g]),
                .ext_step (agu_step[g]),
                .addr     (agu_addr[g]),
                .nxt      (nxt[g])
            );
        end
    endgenerate

    function automatic logic same_target(
        input logic                ptr_a,
        input logic [CAG_SELW-1:0] sel_a,
        input logic                ptr_b,
        input logic [CAG_SELW-1:0] sel_b
    );
        if (ptr_a != ptr_b) begin
            return 1'b0;
        end
        if (ptr_a) begin
            return sel_a[CAG_PTRW-1:0] == sel_b[CAG_PTRW-1:0];
        end
        return sel_a[CAG_SETW-1:0] == sel_b[CAG_SETW-1:0];
    endfunction

    // Writeback arbitration: a lower-numbered port wins a shared target.
    always_comb begin
        coll_err = 1'b0;
        want     = agu_req & agu_upd;
        for (int p = 0; p < NPORT; p++) begin
            wb[p].valid  = want[p];
            wb[p].is_ptr = agu_is_ptr[p];
            wb[p].sel    = agu_sel[p];
            wb[p].value  = nxt[p];
            for (int q = 0; q < p; q++) begin
                if (want[p] && want[q] &&
                    same_target(agu_is_ptr[q], agu_sel[q], agu_is_ptr[p], agu_sel[p])) begin
                    wb[p].valid = 1'b0;
                    coll_err    = 1'b1;
                end
            end
        end
    end

    cag_regfile #(.NPORT(NPORT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb        (wb),
        .cfg_we    (cfg_we),
        .cfg_waddr (cfg_waddr),
        .cfg_wdata (cfg_wdata),
        .sets      (sets),
        .ptrs      (ptrs)
    );

    always_comb begin
        rd_set = sets[cfg_raddr[CAG_SETW-1:0]];
        if (cfg_raddr[CAG_CAW-1]) begin
            cfg_rdata = ptrs[cfg_raddr[CAG_PTRW-1:0]];
        end else begin
            case (cag_field_e'(cfg_raddr[CAG_SETW+1:CAG_SETW]))
                FLD_INDEX: cfg_rdata = rd_set.index;
                FLD_STEP:  cfg_rdata = rd_set.step;
                FLD_SPAN:  cfg_rdata = rd_set.span;
                default:   cfg_rdata = rd_set.origin;
            endcase
        end
    end
endmodule

// File: rtl/cag_checker.sv
module cag_checker
    import cag_pkg::*;
#(
    parameter int unsigned NPORT = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [CAG_CAW-1:0]             cfg_waddr,
    input logic [CAG_AW-1:0]              cfg_wdata,
    input logic [CAG_CAW-1:0]             cfg_raddr,
    input logic [CAG_AW-1:0]              cfg_rdata,
    input logic [NPORT-1:0]               agu_req,
    input logic [NPORT-1:0]               agu_is_ptr,
    input logic [NPORT-1:0][CAG_SELW-1:0] agu_sel,
    input logic [NPORT-1:0]               agu_pre,
    input logic [NPORT-1:0]               agu_upd,
    input logic [NPORT-1:0][CAG_AW-1:0]   agu_addr,
    input logic                           coll_err
);
    logic p0_circ_post;
    logic p1_hits_p0_set;

    assign p0_circ_post   = agu_req[0] && !agu_is_ptr[0] && !agu_pre[0];
    assign p1_hits_p0_set = agu_req[1] && agu_upd[1] && !agu_is_ptr[1] &&
                            (agu_sel[1][CAG_SETW-1:0] == agu_sel[0][CAG_SETW-1:0]);

    // R2: a write is readable at the same address after one edge.
    assert_cfg_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ((cfg_raddr != $past(cfg_waddr)) || (cfg_rdata == $past(cfg_wdata))));

    // R11: a collision can only be flagged when both ports update.
    assert_coll_needs_two_R11: assert property (@(posedge clk) disable iff (!rst_n)
        coll_err |-> (agu_req[0] && agu_req[1] && agu_upd[0] && agu_upd[1]));

    // R5: port 0 pre-modify writeback shows as the next post-modify address.
    assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (agu_req[0] && agu_upd[0] && agu_pre[0] && !agu_is_ptr[0] && !cfg_we)
        |=> (!(p0_circ_post && (agu_sel[0] == $past(agu_sel[0])))
             || (agu_addr[0] == $past(agu_addr[0]))));

    // R5: without update the index holds.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_circ_post && !agu_upd[0] && !cfg_we && !p1_hits_p0_set)
        |=> (!(p0_circ_post && (agu_sel[0][CAG_SETW-1:0] == $past(agu_sel[0][CAG_SETW-1:0])))
             || (agu_addr[0] == $past(agu_addr[0]))));
endmodule

bind circ_addr_unit cag_checker #(.NPORT(NPORT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_waddr  (cfg_waddr),
    .cfg_wdata  (cfg_wdata),
    .cfg_raddr  (cfg_raddr),
    .cfg_rdata  (cfg_rdata),
    .agu_req    (agu_req),
    .agu_is_ptr (agu_is_ptr),
    .agu_sel    (agu_sel),
    .agu_pre    (agu_pre),
    .agu_upd    (agu_upd),
    .agu_addr   (agu_addr),
    .coll_err   (coll_err)
);

// File: tb/tb_circ_addr_unit.sv
module tb_circ_addr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    // Vector table: index, step, span, origin, pre, expected address, expected stored index
    localparam logic [31:0] V_IDX  [NV] = '{32'h100, 32'h10C, 32'h100, 32'h1000, 32'h50,       32'h208};
    localparam logic [31:0] V_STEP [NV] = '{32'h4,   32'h4,   32'hFFFFFFFC, 32'h8, 32'hFFFFFFF0, 32'h8};
    localparam logic [31:0] V_SPAN [NV] = '{32'h10,  32'h10,  32'h10,  32'h0,    32'h0,        32'h20};
    localparam logic [31:0] V_ORG  [NV] = '{32'h100, 32'h100, 32'h100, 32'h2000, 32'h0,        32'h200};
    localparam logic        V_PRE  [NV] = '{1'b0,    1'b1,    1'b0,    1'b1,     1'b0,         1'b1};
    localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h100, 32'h100, 32'h1008, 32'h50,       32'h210};
    localparam logic [31:0] V_NEXT [NV] = '{32'h104, 32'h100, 32'h10C, 32'h1008, 32'h40,       32'h210};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [4:0]        cfg_waddr;
    logic [31:0]       cfg_wdata;
    logic [4:0]        cfg_raddr;
    logic [31:0]       cfg_rdata;
    logic [1:0]        agu_req;
    logic [1:0]        agu_is_ptr;
    logic [1:0][2:0]   agu_sel;
    logic [1:0]        agu_pre;
    logic [1:0]        agu_upd;
    logic [1:0][31:0]  agu_step;
    logic [1:0][31:0]  agu_addr;
    logic              coll_err;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    circ_addr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .agu_req(agu_req), .agu_is_ptr(agu_is_ptr), .agu_sel(agu_sel),
        .agu_pre(agu_pre), .agu_upd(agu_upd), .agu_step(agu_step),
        .agu_addr(agu_addr), .coll_err(coll_err)
    );

    function automatic logic [4:0] fa(input logic [1:0] fld, input logic [1:0] set);
        return {1'b0, fld, set};
    endfunction

    function automatic logic [4:0] pa(input logic [2:0] n);
        return {2'b10, n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        cfg_raddr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic idle_ports();
        agu_req = '0; agu_is_ptr = '0; agu_sel = '0;
        agu_pre = '0; agu_upd = '0; agu_step = '0;
    endtask

    task automatic load_set(input logic [1:0] s, input logic [31:0] i, input logic [31:0] st,
                            input logic [31:0] sp, input logic [31:0] o);
        cfg_write(fa(2'd0, s), i);
        cfg_write(fa(2'd1, s), st);
        cfg_write(fa(2'd2, s), sp);
        cfg_write(fa(2'd3, s), o);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = '0;
        idle_ports();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        read_chk("R1", fa(2'd0, 2'd0), 32'h0);
        read_chk("R1", fa(2'd3, 2'd3), 32'h0);
        read_chk("R1", pa(3'd7), 32'h0);

        // Vector walk: one port-0 request per entry
        for (int i = 0; i < NV; i++) begin
            logic [1:0] s;
            string tag;
            s = 2'(i % 4);
            case (i)
                1:       tag = "R6";
                2:       tag = "R7";
                3:       tag = "R8";
                4:       tag = "R9";
                default: tag = "R4";
            endcase
            load_set(s, V_IDX[i], V_STEP[i], V_SPAN[i], V_ORG[i]);
            agu_req[0] = 1'b1; agu_upd[0] = 1'b1; agu_is_ptr[0] = 1'b0;
            agu_sel[0] = {1'b0, s}; agu_pre[0] = V_PRE[i];
            #1;
            check(tag, agu_addr[0], V_ADDR[i]);
            tick();
            idle_ports();
            read_chk("R5", fa(2'd0, s), V_NEXT[i]);
        end

        // R3 / R2: same-cycle write keeps the old value on the address output
        cfg_write(fa(2'd0, 2'd1), 32'h40);
        cfg_we = 1'b1; cfg_waddr = fa(2'd0, 2'd1); cfg_wdata = 32'h80;
        agu_req[0] = 1'b1; agu_sel[0] = 3'd1; agu_pre[0] = 1'b0;
        #1;
        check("R3", agu_addr[0], 32'h40);
        tick();
        cfg_we = 1'b0;
        #1;
        check("R2", agu_addr[0], 32'h80);
        idle_ports();
        read_chk("R2", fa(2'd0, 2'd1), 32'h80);

        // R12: register write beats a writeback to the same index
        cfg_write(fa(2'd1, 2'd1), 32'h4);
        cfg_write(fa(2'd2, 2'd1), 32'h0);
        cfg_we = 1'b1; cfg_waddr = fa(2'd0, 2'd1); cfg_wdata = 32'h300;
        agu_req[0] = 1'b1; agu_upd[0] = 1'b1; agu_sel[0] = 3'd1;
        tick();
        cfg_we = 1'b0;
        idle_ports();
        read_chk("R12", fa(2'd0, 2'd1), 32'h300);

        // R4: both ports at once on different sets
        load_set(2'd2, 32'h500, 32'h10, 32'h0, 32'h0);
        load_set(2'd3, 32'h600, 32'hFFFFFFF8, 32'h40, 32'h600);
        agu_req = 2'b11; agu_upd = 2'b11; agu_is_ptr = 2'b00;
        agu_sel[0] = 3'd2; agu_pre[0] = 1'b0;
        agu_sel[1] = 3'd3; agu_pre[1] = 1'b1;
        #1;
        check("R4", agu_addr[0], 32'h500);
        check("R7", agu_addr[1], 32'h638);
        check("R11", {31'h0, coll_err}, 32'h0);
        tick();
        idle_ports();
        read_chk("R5", fa(2'd0, 2'd2), 32'h510);
        read_chk("R5", fa(2'd0, 2'd3), 32'h638);

        // R5: no update keeps the index
        agu_req[0] = 1'b1; agu_sel[0] = 3'd2; agu_upd[0] = 1'b0;
        tick();
        idle_ports();
        read_chk("R5", fa(2'd0, 2'd2), 32'h510);

        // R10: pointer registers with external signed step
        cfg_write(pa(3'd2), 32'h2000);
        agu_req[1] = 1'b1; agu_is_ptr[1] = 1'b1; agu_sel[1] = 3'd2;
        agu_pre[1] = 1'b1; agu_upd[1] = 1'b1; agu_step[1] = 32'hFFFFFFFC;
        #1;
        check("R10", agu_addr[1], 32'h1FFC);
        tick();
        read_chk("R10", pa(3'd2), 32'h1FFC);
        agu_pre[1] = 1'b0; agu_step[1] = 32'h4;
        #1;
        check("R10", agu_addr[1], 32'h1FFC);
        tick();
        idle_ports();
        read_chk("R10", pa(3'd2), 32'h2000);

        // R11: both ports update pointer 5; port 0 wins and the flag rises
        cfg_write(pa(3'd5), 32'h1000);
        agu_req = 2'b11; agu_upd = 2'b11; agu_is_ptr = 2'b11;
        agu_sel[0] = 3'd5; agu_sel[1] = 3'd5;
        agu_step[0] = 32'h4; agu_step[1] = 32'hFFFFFFF8;
        #1;
        check("R11", {31'h0, coll_err}, 32'h1);
        tick();
        idle_ports();
        read_chk("R11", pa(3'd5), 32'h1004);
        check("R11", {31'h0, coll_err}, 32'h0);

        // R1: reset mid-run clears loaded registers
        cfg_write(pa(3'd3), 32'hABCD);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        read_chk("R1", pa(3'd3), 32'h0);
        read_chk("R1", fa(2'd0, 2'd2), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule